// File: doc/BRIEF.md
# Decimating Block Averager

This block smooths a stream of unsigned measurement words. Samples arrive on a data bus qualified by a valid strobe. The block adds 2^K consecutive accepted samples into one wide running sum. On the last sample of a block it adds half of the block size to the total and shifts the total right by K bits. The result is one rounded mean per block, in the same LSB units as the input. Blocks never share samples, so the output rate is the input rate divided by 2^K.

A small controller with two named states tracks block progress. `ST_EMPTY` means no sample of the current block has been taken. `ST_FILLING` means at least one has been taken and fewer than 2^K.

Transitions:
- *first-take*: `ST_EMPTY` to `ST_FILLING` on an accepted sample.
- *block-close*: `ST_FILLING` to `ST_EMPTY` on the 2^K-th accepted sample.
- *flush*: any state to `ST_EMPTY` on reset or on the synchronous clear.

Idle cycles leave the state, the sample count and the sum untouched. The clear input lets the consumer throw away a partly gathered block, for example after a change of measurement range.

Top module: `blkavg_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `avg_valid` is 0 and `avg_out` is 0. A reset issued in the middle of a block discards the partial sum and emits no result.
- R2: Each result equals floor((S + 2^(K-1)) / 2^K), where S is the sum of the block's 2^K accepted samples. With the default K = 3 this is (S + 4) >> 3.
- R3: Rounding is half-up. When S mod 2^K is at least 2^(K-1) the result is rounded up. Below that it is rounded down.
- R4: `avg_valid` is high for exactly one clock, in the cycle right after the edge that accepts the 2^K-th sample of a block, and at no other time.
- R5: Blocks do not overlap. The sample accepted after a block closes is the first sample of a new sum, so one result appears per 2^K accepted samples.
- R6: A cycle with `in_valid` low changes neither the sample count nor the sum. A stream with gaps yields the same results as the same samples sent back to back.
- R7: A cycle with `clr` high zeroes the count and the sum. Any sample presented in that cycle is dropped, and the partial block emits no result.
- R8: The sum cannot overflow. A block of all-ones samples yields the all-ones result, 2^W - 1.
- R9: `avg_out` holds the most recent result unchanged until the next block closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the partial block, active high |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | SAMPLE_W | Unsigned measurement sample |
| avg_out | output | SAMPLE_W | Most recent rounded block mean |
| avg_valid | output | 1 | One-cycle strobe marking a fresh `avg_out` |

## Verification
Every result comes from one register stage. A block closed at a rising edge shows its mean and its strobe on the outputs just after that same edge. A clear or reset applied at an edge shows its effect from that edge onward. The bench drives inputs on the falling edge, waits one nanosecond after the next rising edge, and then compares both outputs with a cycle-accurate arithmetic model that is updated for that same edge. Under this scheme a strobe that arrives one cycle early or late fails the check of that cycle, and so does a strobe that lasts two cycles.

// File: rtl/blkavg_pkg.sv
package blkavg_pkg;
    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_FILLING = 1'b1
    } fill_state_t;
endpackage

// File: rtl/blkavg_seq.sv
module blkavg_seq
    import blkavg_pkg::*;
#(
    parameter int LOG2_BLK = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                in_valid,
    output logic                take,
    output logic                close,
    output logic [LOG2_BLK-1:0] cnt_o
);
    localparam int CNT_W = LOG2_BLK;
    localparam logic [CNT_W-1:0] LAST_IDX = {CNT_W{1'b1}};

    fill_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clr || close)
                cnt_q <= '0;
            else if (take)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state and output process
    always_comb begin
        take    = in_valid && !clr;
        close   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (take)
                    state_d = ST_FILLING;   // first-take
            end
            ST_FILLING: begin
                if (take && (cnt_q == LAST_IDX)) begin
                    close   = 1'b1;
                    state_d = ST_EMPTY;     // block-close
                end
            end
            default: state_d = ST_EMPTY;
        endcase
        if (clr)
            state_d = ST_EMPTY;             // flush
    end

    assign cnt_o = cnt_q;

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> $stable(cnt_q));

    // R5
    state_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY) |-> (cnt_q == '0));

    // R7
    clear_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state_q == ST_EMPTY));
endmodule

// File: rtl/blkavg_sum.sv
module blkavg_sum #(
    parameter int SAMPLE_W = 8,
    parameter int LOG2_BLK = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           take,
    input  logic                           close,
    input  logic [SAMPLE_W-1:0]            sample,
    output logic [SAMPLE_W-1:0]            avg_q,
    output logic                           avg_vld_q,
    output logic [SAMPLE_W+LOG2_BLK:0]     sum_o
);
    localparam int ACC_W = SAMPLE_W + LOG2_BLK + 1;
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (LOG2_BLK - 1);

    logic [ACC_W-1:0] sum_q;
    logic [ACC_W-1:0] sum_next;
    logic [ACC_W-1:0] rounded;
    logic [ACC_W-1:0] shifted;

    always_comb begin
        sum_next = sum_q + ACC_W'(sample);
        rounded  = sum_next + HALF;
        shifted  = rounded >> LOG2_BLK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            avg_q     <= '0;
            avg_vld_q <= 1'b0;
        end else begin
            avg_vld_q <= close;
            if (clr || close)
                sum_q <= '0;
            else if (take)
                sum_q <= sum_next;
            if (close)
                avg_q <= shifted[SAMPLE_W-1:0];
        end
    end

    assign sum_o = sum_q;

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        avg_vld_q |=> !avg_vld_q);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum_q == '0));

    // R8
    round_fit_chk: assert property (@(posedge clk) disable iff (rst)
        close |-> (shifted[ACC_W-1:SAMPLE_W] == '0));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !close |=> $stable(avg_q));
endmodule

// File: rtl/blkavg_top.sv
module blkavg_top #(
    parameter int SAMPLE_W = 8,
    parameter int LOG2_BLK = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic [SAMPLE_W-1:0] avg_out,
    output logic                avg_valid
);
    localparam int ACC_W = SAMPLE_W + LOG2_BLK + 1;
    localparam logic [ACC_W-1:0] MAX_S = ACC_W'({SAMPLE_W{1'b1}});

    logic                take, close;
    logic [LOG2_BLK-1:0] cnt;
    logic [ACC_W-1:0]    sum;

    blkavg_seq #(.LOG2_BLK(LOG2_BLK)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .in_valid (in_valid),
        .take     (take),
        .close    (close),
        .cnt_o    (cnt)
    );

    blkavg_sum #(.SAMPLE_W(SAMPLE_W), .LOG2_BLK(LOG2_BLK)) u_sum (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .take      (take),
        .close     (close),
        .sample    (in_data),
        .avg_q     (avg_out),
        .avg_vld_q (avg_valid),
        .sum_o     (sum)
    );

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        sum <= (ACC_W'(cnt) * MAX_S));

    // R4
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr && (cnt == {LOG2_BLK{1'b1}})) |=> avg_valid);
endmodule

// File: tb/tb_blkavg_top.sv
module tb_blkavg_top;
    localparam int W = 8;
    localparam int K = 3;
    localparam int BLK = 1 << K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] avg_out;
    logic         avg_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_sum = 0;
    int m_cnt = 0;
    int exp_out = 0;
    int exp_v = 0;
    int lcg = 12345;

    always #2 clk = ~clk;

    blkavg_top #(.SAMPLE_W(W), .LOG2_BLK(K)) dut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .avg_out(avg_out), .avg_valid(avg_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] d,
                        input logic c, input logic r, input string tag);
        @(negedge clk);
        in_valid = v; in_data = d; clr = c; rst = r;
        @(posedge clk);
        exp_v = 0;
        if (r) begin
            m_sum = 0; m_cnt = 0; exp_out = 0;
        end else if (c) begin
            m_sum = 0; m_cnt = 0;
        end else if (v) begin
            m_sum += d; m_cnt++;
            if (m_cnt == BLK) begin
                exp_out = (m_sum + BLK / 2) / BLK;
                exp_v = 1;
                m_sum = 0; m_cnt = 0;
            end
        end
        #1;
        check({tag, " valid"}, int'(avg_valid), exp_v);
        check({tag, " out"}, int'(avg_out), exp_out);
    endtask

    function automatic int next_rand();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return lcg >>> 8;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1'b0, '0, 1'b0, 1'b1, "R1");
        step(1'b1, 8'd200, 1'b0, 1'b1, "R1");
        step(1'b0, '0, 1'b0, 1'b0, "R1");

        // R2 R5 R8 constant blocks back to back, including all-ones
        for (int v = 0; v <= 255; v += 17)
            for (int i = 0; i < BLK; i++)
                step(1'b1, W'(v), 1'b0, 1'b0, "R2 R5 R8");

        // R3 rounding sweep over every remainder
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < BLK; r++)
                for (int i = 0; i < BLK; i++)
                    step(1'b1, (i == 0) ? W'(b * 200 + r) : W'(b * 200),
                         1'b0, 1'b0, "R3");

        // R9 hold after a pulse with idle cycles
        for (int i = 0; i < 6; i++)
            step(1'b0, 8'hA5, 1'b0, 1'b0, "R9");

        // R4 R6 random data with random gaps
        for (int i = 0; i < 400; i++) begin
            int x;
            x = next_rand();
            step(x[0] | x[1], W'(x >>> 4), 1'b0, 1'b0, "R4 R6");
        end
        while (m_cnt != 0)
            step(1'b1, 8'd33, 1'b0, 1'b0, "R4 R6");

        // R7 clear mid block, clear with a sample present
        for (int i = 0; i < 5; i++)
            step(1'b1, 8'd250, 1'b0, 1'b0, "R7");
        step(1'b1, 8'd255, 1'b1, 1'b0, "R7");
        for (int i = 0; i < BLK; i++)
            step(1'b1, W'(10 + i), 1'b0, 1'b0, "R7");
        for (int i = 0; i < BLK - 1; i++)
            step(1'b1, 8'd90, 1'b0, 1'b0, "R7");
        step(1'b0, '0, 1'b1, 1'b0, "R7");
        for (int i = 0; i < BLK; i++)
            step(1'b1, 8'd3, 1'b0, 1'b0, "R7");

        // R1 reset mid block discards partial sum
        for (int i = 0; i < 3; i++)
            step(1'b1, 8'd180, 1'b0, 1'b0, "R1");
        step(1'b0, '0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < BLK; i++)
            step(1'b1, W'(i * 9), 1'b0, 1'b0, "R1");
        step(1'b0, '0, 1'b0, 1'b0, "R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule